// File: doc/BRIEF.md
# Adapter Option-Select Registers and Shared-Window Decoder

This block is the configuration front end of an add-in network adapter. It claims a run of eight consecutive host I/O ports whose base is fixed by board straps. Two of those ports hand back a constant card identifier, so probe software can tell which base the card sits at. A third port holds the card-enable and boot-ROM-disable flags. A fourth port holds the six high host address bits that place a 16 KB shared-memory window.

The second half of the block watches host memory addresses. When the card is enabled and an address falls in the programmed 16 KB window, it picks one target. The target is the shared RAM, the station-address PROM (bytes on even addresses only), the 16-bit controller data register, the status/control byte or the command byte. It also reports the in-window offset. A separate level tells the board whether the boot ROM may answer.

Top module: `optsel_cfg`

## Requirements
- R1: An I/O access hits only when ioAddr[9:3] equals ioBaseStrap; the port number is ioAddr[2:0]. A miss reads 0x00 and a write that misses changes no register.
- R2: Port 0 reads 0xFD and port 1 reads 0x6A. Writes to them are ignored.
- R3: Port 2 bit 0 is the card enable and bit 1 is the boot-ROM disable. A read returns those two bits in the same positions, with bits 7:2 zero. Written bits 7:2 are dropped.
- R4: Port 3 bits 5:0 hold window base bits A19..A14 and read back with bits 7:6 zero.
- R5: Ports 4 to 7 read 0x00, and writes to them are ignored.
- R6: Reset clears port 2 and port 3 to zero.
- R7: A memory address is in the window when memAddr[19:14] equals the port 3 base. Offsets 0x0000..0x3FBF select the shared RAM (selRam). winOffset always equals memAddr[13:0].
- R8: Offsets 0x3FC0..0x3FDF select the PROM (selProm). promOdd is high exactly when the PROM is selected at an odd offset.
- R9: Offsets 0x3FE0..0x3FEF and 0x3FF4..0x3FFF select nothing, and neither does any address outside the window.
- R10: Offsets 0x3FF0..0x3FF1 select the data register (selData), 0x3FF2 the status/control byte (selStat) and 0x3FF3 the command byte (selCmd). At most one select is high at a time.
- R11: While the card-enable bit is 0, no region select is high.
- R12: bootRomEn is high exactly when the card is enabled and the ROM-disable bit is 0. A port 2 write takes effect from the next clock edge.
- R13: Reads are combinational in the cycle ioRd is high. While ioRd is low, ioRdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioBaseStrap | input | 7 | Strapped I/O base, host address bits 9:3 |
| ioAddr | input | 10 | Host I/O address |
| ioRd | input | 1 | I/O read strobe |
| ioWr | input | 1 | I/O write strobe |
| ioWdata | input | 8 | I/O write data |
| ioRdata | output | 8 | I/O read data, zero when not reading or on a miss |
| memAddr | input | 20 | Host memory address |
| selRam | output | 1 | Shared RAM selected |
| selProm | output | 1 | Address PROM selected |
| promOdd | output | 1 | PROM selected at an odd (invalid) byte |
| selData | output | 1 | 16-bit controller data register selected |
| selStat | output | 1 | Status/control byte selected |
| selCmd | output | 1 | Command byte selected |
| winOffset | output | 14 | Offset of memAddr inside the window |
| bootRomEn | output | 1 | Boot ROM allowed to respond |

## Verification
The checker watches several rules on every cycle. The region selects never overlap. No select appears while a shadow of the enable bit is clear. The identifier bytes come back whenever port 0 or 1 is read. The read bus stays quiet without a read strobe. A port 2 write shows up one edge later on bootRomEn. The bench covers the rest with sweeps. It places each window offset in the right region, confirms that writes to read-only and unused ports leave every readable value alone, and shows that all 64 base values round-trip and move the window.

// File: rtl/optsel_pkg.sv
package optsel_pkg;
  localparam logic [7:0] ID_LOW  = 8'hFD;
  localparam logic [7:0] ID_HIGH = 8'h6A;

  localparam logic [2:0] PORT_IDLO = 3'd0;
  localparam logic [2:0] PORT_IDHI = 3'd1;
  localparam logic [2:0] PORT_CTL  = 3'd2;
  localparam logic [2:0] PORT_BASE = 3'd3;

  typedef struct packed {
    logic       rdEn;
    logic [2:0] rdPort;
    logic       wrCtl;
    logic       wrBase;
  } ioStrobe_t;
endpackage

// File: rtl/optsel_ctrl.sv
module optsel_ctrl
  import optsel_pkg::*;
#(
  parameter int IO_AW = 10
) (
  input  logic [IO_AW-1:3] ioBaseStrap,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             ioRd,
  input  logic             ioWr,
  output ioStrobe_t        stb
);
  logic ioHit;
  logic [2:0] port;

  assign ioHit = (ioAddr[IO_AW-1:3] == ioBaseStrap);
  assign port  = ioAddr[2:0];

  always_comb begin
    stb.rdEn   = ioHit && ioRd;
    stb.rdPort = port;
    stb.wrCtl  = ioHit && ioWr && (port == PORT_CTL);
    stb.wrBase = ioHit && ioWr && (port == PORT_BASE);
  end
endmodule

// File: rtl/optsel_regs.sv
module optsel_regs
  import optsel_pkg::*;
#(
  parameter int BASE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobe_t         stb,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic              cardEn,
  output logic              romDis,
  output logic [BASE_W-1:0] winBase
);
  logic unusedHiBits;
  assign unusedHiBits = ^ioWdata[7:BASE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cardEn  <= 1'b0;
      romDis  <= 1'b0;
      winBase <= '0;
    end else begin
      if (stb.wrCtl) begin
        cardEn <= ioWdata[0];
        romDis <= ioWdata[1];
      end
      if (stb.wrBase) winBase <= ioWdata[BASE_W-1:0];
    end
  end

  always_comb begin
    ioRdata = 8'h00;
    if (stb.rdEn) begin
      case (stb.rdPort)
        PORT_IDLO: ioRdata = ID_LOW;
        PORT_IDHI: ioRdata = ID_HIGH;
        PORT_CTL:  ioRdata = {6'b0, romDis, cardEn};
        PORT_BASE: ioRdata = {{(8-BASE_W){1'b0}}, winBase};
        default:   ioRdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/optsel_windec.sv
module optsel_windec #(
  parameter int MEM_AW = 20,
  parameter int WIN_AW = 14
) (
  input  logic [MEM_AW-1:0]      memAddr,
  input  logic                   cardEn,
  input  logic [MEM_AW-WIN_AW-1:0] winBase,
  output logic                   selRam,
  output logic                   selProm,
  output logic                   promOdd,
  output logic                   selData,
  output logic                   selStat,
  output logic                   selCmd,
  output logic [WIN_AW-1:0]      winOffset
);
  localparam int WIN_SIZE  = 1 << WIN_AW;
  localparam int PROM_LO   = WIN_SIZE - 64;
  localparam int RSV_LO    = PROM_LO + 32;
  localparam int DATA_LO   = RSV_LO + 16;
  localparam int STAT_AT   = DATA_LO + 2;
  localparam int CMD_AT    = DATA_LO + 3;

  logic inWin;
  int unsigned off;

  assign winOffset = memAddr[WIN_AW-1:0];
  assign inWin = cardEn && (memAddr[MEM_AW-1:WIN_AW] == winBase);

  always_comb begin
    off     = int'(memAddr[WIN_AW-1:0]);
    selRam  = inWin && (off < PROM_LO);
    selProm = inWin && (off >= PROM_LO) && (off < RSV_LO);
    selData = inWin && (off >= DATA_LO) && (off < STAT_AT);
    selStat = inWin && (off == STAT_AT);
    selCmd  = inWin && (off == CMD_AT);
    promOdd = selProm && memAddr[0];
  end
endmodule

// File: rtl/optsel_cfg.sv
module optsel_cfg
  import optsel_pkg::*;
#(
  parameter int IO_AW  = 10,
  parameter int MEM_AW = 20,
  parameter int WIN_AW = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IO_AW-1:3]  ioBaseStrap,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  input  logic [MEM_AW-1:0] memAddr,
  output logic              selRam,
  output logic              selProm,
  output logic              promOdd,
  output logic              selData,
  output logic              selStat,
  output logic              selCmd,
  output logic [WIN_AW-1:0] winOffset,
  output logic              bootRomEn
);
  localparam int BASE_W = MEM_AW - WIN_AW;

  ioStrobe_t stb;
  logic cardEn, romDis;
  logic [BASE_W-1:0] winBase;

  optsel_ctrl #(.IO_AW(IO_AW)) u_ctrl (
    .ioBaseStrap(ioBaseStrap), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .stb(stb)
  );

  optsel_regs #(.BASE_W(BASE_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .cardEn(cardEn), .romDis(romDis), .winBase(winBase)
  );

  optsel_windec #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW)) u_dec (
    .memAddr(memAddr), .cardEn(cardEn), .winBase(winBase),
    .selRam(selRam), .selProm(selProm), .promOdd(promOdd), .selData(selData),
    .selStat(selStat), .selCmd(selCmd), .winOffset(winOffset)
  );

  assign bootRomEn = cardEn && !romDis;
endmodule

// File: rtl/optsel_cfg_chk.sv
module optsel_cfg_chk #(
  parameter int IO_AW = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [IO_AW-1:3] ioBaseStrap,
  input logic [IO_AW-1:0] ioAddr,
  input logic             ioRd,
  input logic             ioWr,
  input logic [7:0]       ioWdata,
  input logic [7:0]       ioRdata,
  input logic             selRam,
  input logic             selProm,
  input logic             selData,
  input logic             selStat,
  input logic             selCmd,
  input logic             bootRomEn
);
  logic hit;
  logic enShadow;
  assign hit = (ioAddr[IO_AW-1:3] == ioBaseStrap);

  always_ff @(posedge clk) begin
    if (!rstN) enShadow <= 1'b0;
    else if (hit && ioWr && ioAddr[2:0] == 3'd2) enShadow <= ioWdata[0];
  end

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selRam, selProm, selData, selStat, selCmd}));

  p_card_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enShadow |-> !(selRam || selProm || selData || selStat || selCmd));

  p_id_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && hit && ioAddr[2:0] == 3'd0) |-> ioRdata == 8'hFD);

  p_id_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && hit && ioAddr[2:0] == 3'd1) |-> ioRdata == 8'h6A);

  p_quiet_bus_r13: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> ioRdata == 8'h00);

  p_rom_enable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (hit && ioWr && ioAddr[2:0] == 3'd2) |=>
      bootRomEn == ($past(ioWdata[0]) && !$past(ioWdata[1])));
endmodule

bind optsel_cfg optsel_cfg_chk #(.IO_AW(IO_AW)) u_chk (.*);

// File: tb/optsel_cfg_test.sv
module optsel_cfg_test;
  localparam int CLK_NS = 20;
  localparam logic [6:0] STRAP = 7'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] ioAddr = '0;
  logic ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] ioWdata = '0;
  logic [7:0] ioRdata;
  logic [19:0] memAddr = '0;
  logic selRam, selProm, promOdd, selData, selStat, selCmd, bootRomEn;
  logic [13:0] winOffset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  optsel_cfg uut (
    .clk(clk), .rstN(rstN), .ioBaseStrap(STRAP), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioWr(ioWr), .ioWdata(ioWdata), .ioRdata(ioRdata), .memAddr(memAddr),
    .selRam(selRam), .selProm(selProm), .promOdd(promOdd), .selData(selData),
    .selStat(selStat), .selCmd(selCmd), .winOffset(winOffset), .bootRomEn(bootRomEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [6:0] blk, input logic [2:0] port, input logic [7:0] d);
    @(negedge clk);
    ioAddr = {blk, port}; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [6:0] blk, input logic [2:0] port, output logic [7:0] d);
    @(negedge clk);
    ioAddr = {blk, port}; ioRd = 1'b1;
    #2 d = ioRdata;
    ioRd = 1'b0;
  endtask

  function automatic int expRegion(input int off);
    if (off < 16'h3FC0) return 1;
    if (off < 16'h3FE0) return 2;
    if (off < 16'h3FF0) return 0;
    if (off < 16'h3FF2) return 4;
    if (off == 16'h3FF2) return 8;
    if (off == 16'h3FF3) return 16;
    return 0;
  endfunction

  task automatic memProbe(input logic [5:0] base, input int off, input int expSel,
                          input string req);
    int got;
    memAddr = {base, 14'(off)};
    #1;
    got = {selCmd, selStat, selData, selProm, selRam};
    check(got == expSel, req, got, expSel);
    check(promOdd == (expSel == 2 && off[0]), "R8 promOdd", promOdd, (expSel == 2 && off[0]));
    check(winOffset == 14'(off), "R7 winOffset", winOffset, off);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R6: reset state
    ioRead(STRAP, 3'd2, d); check(d == 8'h00, "R6 port2 after reset", d, 0);
    ioRead(STRAP, 3'd3, d); check(d == 8'h00, "R6 port3 after reset", d, 0);
    check(bootRomEn == 1'b0, "R12 bootRomEn after reset", bootRomEn, 0);
    // R11: base 0 matches address 0 but card disabled
    memProbe(6'd0, 0, 0, "R11 disabled after reset");

    // R13: no read strobe gives zero bus
    @(negedge clk); ioAddr = {STRAP, 3'd0}; #1;
    check(ioRdata == 8'h00, "R13 idle bus", ioRdata, 0);

    // R2 R5: writes to read-only and unused ports are ignored
    for (int p = 0; p < 8; p++)
      if (p != 2 && p != 3) ioWrite(STRAP, 3'(p), 8'hFF);
    for (int p = 0; p < 8; p++) begin
      int e;
      ioRead(STRAP, 3'(p), d);
      e = (p == 0) ? 8'hFD : (p == 1) ? 8'h6A : 0;
      check(d == 8'(e), (p < 2) ? "R2 identifier" : "R5 unused or cleared port", d, e);
    end

    // R3 R12: control port sweep with junk in upper bits
    for (int v = 0; v < 16; v++) begin
      logic [7:0] w;
      w = 8'((v << 4) | (v & 3)) | 8'hA0;
      ioWrite(STRAP, 3'd2, w);
      ioRead(STRAP, 3'd2, d);
      check(d == 8'(v & 3), "R3 control readback", d, v & 3);
      check(bootRomEn == ((v & 1) && !(v & 2)), "R12 bootRomEn", bootRomEn,
            int'((v & 1) && !(v & 2)));
    end

    // R4: every base value round-trips, upper bits dropped
    for (int v = 0; v < 64; v++) begin
      ioWrite(STRAP, 3'd3, 8'(v) | 8'hC0);
      ioRead(STRAP, 3'd3, d);
      check(d == 8'(v), "R4 base readback", d, v);
    end

    // R1: other I/O blocks neither write nor read
    ioWrite(STRAP + 7'd1, 3'd3, 8'h15);
    ioWrite(STRAP - 7'd1, 3'd2, 8'h02);
    ioRead(STRAP, 3'd3, d); check(d == 8'h3F, "R1 base unchanged by miss", d, 8'h3F);
    ioRead(STRAP, 3'd2, d); check(d == 8'h03, "R1 control unchanged by miss", d, 3);
    ioRead(STRAP + 7'd1, 3'd0, d); check(d == 8'h00, "R1 miss reads zero", d, 0);

    // R7 R8 R9 R10: exhaustive window sweep, card on
    ioWrite(STRAP, 3'd2, 8'h01);
    ioWrite(STRAP, 3'd3, 8'h33);
    @(negedge clk);
    for (int off = 0; off < 16384; off++)
      memProbe(6'h33, off, expRegion(off), "R7 R8 R9 R10 region decode");
    // R9: neighbouring windows select nothing
    for (int off = 0; off < 16384; off += 97) begin
      memProbe(6'h32, off, 0, "R9 below window");
      memProbe(6'h34, off, 0, "R9 above window");
    end

    // R11: card disabled, ROM disable set
    ioWrite(STRAP, 3'd2, 8'h02);
    @(negedge clk);
    check(bootRomEn == 1'b0, "R12 bootRomEn card off", bootRomEn, 0);
    for (int off = 0; off < 16384; off += 61)
      memProbe(6'h33, off, 0, "R11 card disabled");
    memProbe(6'h33, 16'h3FF3, 0, "R11 card disabled cmd");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule